// File: doc/BRIEF.md
# Banked RTC extended RAM port

This block is the register-file front end of a clock chip in the style of the classic 146818 real-time clock. A host reaches it through a latched address: an address strobe captures a 7-bit location from the shared data bus, and read and write strobes then move bytes to or from that location. The lower 64 locations always reach the clock and user register bytes. The upper 64 locations reach either more user RAM or a second page of extension registers. The choice is made by a page bit held in the divider byte at location 0x0A.

The extension page reaches a larger battery-backed SRAM indirectly. A 16-bit pointer is split over a low and a high byte, and a data window reads or writes the SRAM byte the pointer selects. In burst mode every window access advances the pointer afterwards. The page also holds identity bytes that come from parameters and cannot be written, a writable century byte, a date-alarm byte and two control bytes, a count of write cycles, and a small history of previously latched addresses. That history lets an interrupt handler find out where an interrupted access was pointing.

Top module: `rtcx_port`

## Requirements
- R1: The page bit is bit 4 of the byte at location 0x0A. When it is 0, locations 0x40–0x7F read and write user RAM. When it is 1, they reach the extension page and the user RAM there is left untouched. Locations 0x00–0x3F are user RAM whatever the page bit is.
- R2: A read strobe raises `rd_valid` for exactly one cycle, on the clock edge after the strobe, with the byte on `rd_data`. Outside that cycle `rd_valid` is 0, and it is 0 after reset.
- R3: In the extension page, 0x50 is the pointer low byte, 0x51 the pointer high byte and 0x53 the data window. The window reaches SRAM byte ({high,low} modulo `XRAM_BYTES`).
- R4: While bit 5 of extension byte 0x4A is 1, each read or write of the window adds one to the pointer low byte after the access. A wrap of the low byte from 0xFF to 0x00 carries into the high byte only when `XRAM_BYTES` exceeds 256. While bit 5 is 0 the pointer is not changed by window accesses.
- R5: When `XRAM_BYTES` is 256 or less, writes to the pointer high byte are ignored and it reads as 0x00.
- R6: The 8-bit write counter at extension byte 0x5E goes up by one, wrapping, on every write strobe, whatever the target. Writes aimed at 0x5E itself change nothing else.
- R7: Extension byte 0x40 reads the `MODEL_ID` parameter. Bytes 0x41–0x46 read `SERIAL`, with the least significant byte at 0x41. Byte 0x47 reads `SERIAL_CRC`. Writes to these bytes and to the reserved extension bytes (0x4C–0x4F, 0x52, 0x54–0x7F) are discarded, and the reserved bytes other than 0x4E, 0x4F and 0x5E read as 0x00.
- R8: A read of extension byte 0x4A always returns bit 7 (auxiliary battery good) as 1. The other bits are as last written.
- R9: Every address strobe pushes a three-deep history. The third entry takes the second, the second takes the first, and the first takes the previously latched address with the page bit in bit 7. Extension bytes 0x4E and 0x4F read the second and third entries.
- R10: Extension bytes 0x48 (century), 0x49 (date alarm), 0x4A, 0x4B and 0x50 read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address strobe; latches `ad_in[6:0]` |
| rd | input | 1 | Read strobe for the latched location |
| wr | input | 1 | Write strobe; writes `ad_in` to the latched location |
| ad_in | input | 8 | Shared address/data bus from the host |
| rd_data | output | 8 | Read byte, valid while `rd_valid` is 1 |
| rd_valid | output | 1 | One-cycle qualifier for `rd_data` |

## Verification
An address or write strobe changes state at the edge where it is sampled. The register write, the pointer step and the counter all take effect at that edge, so the next strobe already sees them. Read data, including SRAM window data, is due at the edge after the read strobe. The bench raises each strobe at a falling edge and holds it for exactly one cycle. It samples `rd_data` and `rd_valid` at the falling edge after that rising edge, which makes a one-cycle latency error show up as a mismatch. A reference model in the bench is updated at the same strobe points, so every expected byte already includes the effect of the writes and burst steps before it.

// File: rtl/rtcx_pkg.sv
package rtcx_pkg;
  localparam int LA_W = 7;
  localparam logic [LA_W-1:0] LOC_DIV   = 7'h0A;
  localparam logic [LA_W-1:0] XR_CENT   = 7'h48;
  localparam logic [LA_W-1:0] XR_DALM   = 7'h49;
  localparam logic [LA_W-1:0] XR_CTLA   = 7'h4A;
  localparam logic [LA_W-1:0] XR_CTLB   = 7'h4B;
  localparam logic [LA_W-1:0] XR_HIST2  = 7'h4E;
  localparam logic [LA_W-1:0] XR_HIST3  = 7'h4F;
  localparam logic [LA_W-1:0] XR_PLO    = 7'h50;
  localparam logic [LA_W-1:0] XR_PHI    = 7'h51;
  localparam logic [LA_W-1:0] XR_WIN    = 7'h53;
  localparam logic [LA_W-1:0] XR_WCNT   = 7'h5E;
  localparam int PAGE_BIT  = 4;
  localparam int BURST_BIT = 5;
  localparam int AUXOK_BIT = 7;
  typedef enum logic [1:0] {SRC_UR, SRC_XR, SRC_REG} rsrc_t;
endpackage

// File: rtl/rtcx_sram.sv
module rtcx_sram #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rtcx_stack.sv
module rtcx_stack #(
  parameter int W     = 8,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic [W-1:0] ent2,
  output logic [W-1:0] ent3
);
  logic [W-1:0] s [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) s[0] <= '0;
    else if (push) s[0] <= din;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_shift
    always_ff @(posedge clk) begin
      if (rst) s[g] <= '0;
      else if (push) s[g] <= s[g-1];
    end
  end

  assign ent2 = s[1];
  assign ent3 = s[2];
endmodule

// File: rtl/rtcx_xptr.sv
module rtcx_xptr #(
  parameter int SIZE = 2048,
  localparam int AW  = $clog2(SIZE),
  localparam bit HI_EN = (SIZE > 256)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [7:0]    wdata,
  input  logic          step,
  output logic [7:0]    lo,
  output logic [7:0]    hi,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lo <= '0;
      hi <= '0;
    end else begin
      if (wr_lo) lo <= wdata;
      else if (step) lo <= lo + 8'd1;
      if (wr_hi && HI_EN) hi <= wdata;
      else if (step && HI_EN && lo == 8'hFF) hi <= hi + 8'd1;
    end
  end

  if (AW <= 8) begin : g_narrow
    assign addr = lo[AW-1:0];
  end else begin : g_wide
    assign addr = {hi[AW-9:0], lo};
  end
endmodule

// File: rtl/rtcx_port.sv
module rtcx_port #(
  parameter int          XRAM_BYTES = 2048,
  parameter logic [7:0]  MODEL_ID   = 8'h72,
  parameter logic [47:0] SERIAL     = 48'h5A3C96E10F77,
  parameter logic [7:0]  SERIAL_CRC = 8'hB4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ale,
  input  logic       rd,
  input  logic       wr,
  input  logic [7:0] ad_in,
  output logic [7:0] rd_data,
  output logic       rd_valid
);
  import rtcx_pkg::*;
  localparam int XAW = $clog2(XRAM_BYTES);

  logic [LA_W-1:0] idx_q;
  logic            bank_q;
  logic [7:0]      cent_q, dalm_q, ctla_q, ctlb_q, wcnt_q;
  logic [7:0]      stk_e2, stk_e3;
  logic [7:0]      ptr_lo, ptr_hi;
  logic [XAW-1:0]  xaddr;
  logic [7:0]      ur_q, xr_q, reg_q, reg_val;
  rsrc_t           src_q;
  logic [7:0]      id_b [8];

  logic in_ext, win_hit, step, wr_lo, wr_hi;
  assign in_ext  = idx_q[LA_W-1] & bank_q;
  assign win_hit = in_ext && (idx_q == XR_WIN);
  assign step    = (rd | wr) & win_hit & ctla_q[BURST_BIT];
  assign wr_lo   = wr & in_ext & (idx_q == XR_PLO);
  assign wr_hi   = wr & in_ext & (idx_q == XR_PHI);

  assign id_b[0] = MODEL_ID;
  assign id_b[7] = SERIAL_CRC;
  for (genvar g = 1; g < 7; g++) begin : g_ser
    assign id_b[g] = SERIAL[8*(g-1) +: 8];
  end

  rtcx_sram #(.DEPTH(1 << LA_W), .DW(8)) u_uram (
    .clk(clk), .we(wr & ~in_ext), .waddr(idx_q), .wdata(ad_in),
    .re(rd & ~in_ext), .raddr(idx_q), .rdata(ur_q)
  );

  rtcx_sram #(.DEPTH(XRAM_BYTES), .DW(8)) u_xram (
    .clk(clk), .we(wr & win_hit), .waddr(xaddr), .wdata(ad_in),
    .re(rd & win_hit), .raddr(xaddr), .rdata(xr_q)
  );

  rtcx_xptr #(.SIZE(XRAM_BYTES)) u_xptr (
    .clk(clk), .rst(rst), .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(ad_in),
    .step(step), .lo(ptr_lo), .hi(ptr_hi), .addr(xaddr)
  );

  rtcx_stack #(.W(8), .DEPTH(3)) u_hist (
    .clk(clk), .rst(rst), .push(ale), .din({bank_q, idx_q}),
    .ent2(stk_e2), .ent3(stk_e3)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      bank_q <= 1'b0;
      cent_q <= '0;
      dalm_q <= '0;
      ctla_q <= '0;
      ctlb_q <= '0;
      wcnt_q <= '0;
    end else begin
      if (ale) idx_q <= ad_in[LA_W-1:0];
      if (wr) begin
        wcnt_q <= wcnt_q + 8'd1;
        if (!in_ext && idx_q == LOC_DIV) bank_q <= ad_in[PAGE_BIT];
        if (in_ext) begin
          case (idx_q)
            XR_CENT: cent_q <= ad_in;
            XR_DALM: dalm_q <= ad_in;
            XR_CTLA: ctla_q <= ad_in;
            XR_CTLB: ctlb_q <= ad_in;
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    reg_val = '0;
    case (idx_q)
      XR_CENT:  reg_val = cent_q;
      XR_DALM:  reg_val = dalm_q;
      XR_CTLA:  reg_val = ctla_q | (8'h1 << AUXOK_BIT);
      XR_CTLB:  reg_val = ctlb_q;
      XR_HIST2: reg_val = stk_e2;
      XR_HIST3: reg_val = stk_e3;
      XR_PLO:   reg_val = ptr_lo;
      XR_PHI:   reg_val = ptr_hi;
      XR_WCNT:  reg_val = wcnt_q;
      default:  if (idx_q[LA_W-1:3] == 4'b1000) reg_val = id_b[idx_q[2:0]];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      src_q    <= SRC_REG;
      reg_q    <= '0;
    end else begin
      rd_valid <= rd;
      if (rd) begin
        src_q <= !in_ext ? SRC_UR : (win_hit ? SRC_XR : SRC_REG);
        reg_q <= reg_val;
      end
    end
  end

  always_comb begin
    case (src_q)
      SRC_UR:  rd_data = ur_q;
      SRC_XR:  rd_data = xr_q;
      default: rd_data = reg_q;
    endcase
  end
endmodule

// File: rtl/rtcx_port_chk.sv
module rtcx_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       ale,
  input logic       rd,
  input logic       wr,
  input logic       rd_valid,
  input logic       bank_q,
  input logic       step,
  input logic [7:0] wcnt_q,
  input logic [7:0] stk_e2,
  input logic [7:0] stk_e3,
  input logic [7:0] ptr_lo
);
  assert_rd_valid_R2: assert property (@(posedge clk) disable iff (rst)
    rd |=> rd_valid);
  assert_rd_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !rd |=> !rd_valid);
  assert_wcnt_step_R6: assert property (@(posedge clk) disable iff (rst)
    wr |=> wcnt_q == $past(wcnt_q) + 8'd1);
  assert_wcnt_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(wcnt_q));
  assert_hist_shift_R9: assert property (@(posedge clk) disable iff (rst)
    ale |=> stk_e3 == $past(stk_e2));
  assert_burst_step_R4: assert property (@(posedge clk) disable iff (rst)
    step |=> ptr_lo == $past(ptr_lo) + 8'd1);
  assert_page_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(bank_q));
endmodule

bind rtcx_port rtcx_port_chk u_chk (
  .clk(clk), .rst(rst), .ale(ale), .rd(rd), .wr(wr), .rd_valid(rd_valid),
  .bank_q(bank_q), .step(step), .wcnt_q(wcnt_q), .stk_e2(stk_e2),
  .stk_e3(stk_e3), .ptr_lo(ptr_lo)
);

// File: tb/rtcx_port_tb.sv
module rtcx_port_tb;
  localparam logic [7:0]  T_MODEL = 8'h72;
  localparam logic [47:0] T_SER   = 48'h5A3C96E10F77;
  localparam logic [7:0]  T_CRC   = 8'hB4;
  localparam int          T_SIZE  = 2048;

  logic clk = 0, rst = 1, ale = 0, rd = 0, wr = 0;
  logic [7:0] ad_in = 0;
  logic [7:0] rd_data, rd_data_s;
  logic rd_valid, rd_valid_s;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  rtcx_port #(.XRAM_BYTES(T_SIZE), .MODEL_ID(T_MODEL), .SERIAL(T_SER), .SERIAL_CRC(T_CRC)) u_dut (
    .clk(clk), .rst(rst), .ale(ale), .rd(rd), .wr(wr), .ad_in(ad_in),
    .rd_data(rd_data), .rd_valid(rd_valid));

  rtcx_port #(.XRAM_BYTES(128), .MODEL_ID(8'h71), .SERIAL(T_SER), .SERIAL_CRC(T_CRC)) u_small (
    .clk(clk), .rst(rst), .ale(ale), .rd(rd), .wr(wr), .ad_in(ad_in),
    .rd_data(rd_data_s), .rd_valid(rd_valid_s));

  // reference model of u_dut
  logic [7:0] m_ur [128];
  logic [7:0] m_xr [T_SIZE];
  logic [6:0] m_idx;
  logic m_bank;
  logic [7:0] m_cent, m_dalm, m_ctla, m_ctlb, m_wcnt, m_lo, m_hi, m_s1, m_s2, m_s3;
  logic [7:0] small_last;

  function automatic bit m_ext();
    return m_idx[6] && m_bank;
  endfunction

  function automatic int m_ptr();
    return int'({m_hi, m_lo}) % T_SIZE;
  endfunction

  function automatic logic [7:0] m_val();
    if (!m_ext()) return m_ur[m_idx];
    case (m_idx)
      7'h40: return T_MODEL;
      7'h41, 7'h42, 7'h43, 7'h44, 7'h45, 7'h46: return T_SER[8*(int'(m_idx)-'h41) +: 8];
      7'h47: return T_CRC;
      7'h48: return m_cent;
      7'h49: return m_dalm;
      7'h4A: return m_ctla | 8'h80;
      7'h4B: return m_ctlb;
      7'h4E: return m_s2;
      7'h4F: return m_s3;
      7'h50: return m_lo;
      7'h51: return m_hi;
      7'h53: return m_xr[m_ptr()];
      7'h5E: return m_wcnt;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string req_of();
    if (!m_ext()) return "R1";
    case (m_idx)
      7'h4A: return "R8";
      7'h4E, 7'h4F: return "R9";
      7'h48, 7'h49, 7'h4B: return "R10";
      7'h50, 7'h51, 7'h53: return "R3";
      7'h5E: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic void m_step();
    if (m_ext() && m_idx == 7'h53 && m_ctla[5]) begin
      m_lo = m_lo + 8'd1;
      if (m_lo == 8'h00) m_hi = m_hi + 8'd1;
    end
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_ale(logic [7:0] a);
    @(negedge clk); ale = 1; ad_in = a;
    @(negedge clk); ale = 0;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = {m_bank, m_idx};
    m_idx = a[6:0];
  endtask

  task automatic do_wr(logic [7:0] d);
    @(negedge clk); wr = 1; ad_in = d;
    @(negedge clk); wr = 0;
    m_wcnt = m_wcnt + 8'd1;
    if (!m_ext()) begin
      m_ur[m_idx] = d;
      if (m_idx == 7'h0A) m_bank = d[4];
    end else begin
      case (m_idx)
        7'h48: m_cent = d;
        7'h49: m_dalm = d;
        7'h4A: m_ctla = d;
        7'h4B: m_ctlb = d;
        7'h50: m_lo = d;
        7'h51: m_hi = d;
        7'h53: m_xr[m_ptr()] = d;
        default: ;
      endcase
      m_step();
    end
  endtask

  // read and compare u_dut against the model; rd_data is due one edge after rd (R2)
  task automatic do_rd(string req);
    logic [7:0] exp;
    exp = m_val();
    @(negedge clk); rd = 1;
    @(negedge clk); rd = 0;
    small_last = rd_data_s;
    checks++;
    if (rd_valid !== 1'b1) begin
      errors++;
      $display("FAIL R2 rd_valid actual %b expected 1", rd_valid);
    end
    chk(req, rd_data, exp);
    m_step();
    @(negedge clk);
    chk("R2", {7'd0, rd_valid}, 8'd0);
  endtask

  task automatic wr_at(logic [7:0] a, logic [7:0] d);
    do_ale(a); do_wr(d);
  endtask

  task automatic rd_at(logic [7:0] a, string req);
    do_ale(a); do_rd(req);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL R2 watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) m_ur[i] = 0;
    for (int i = 0; i < T_SIZE; i++) m_xr[i] = 0;
    m_idx = 0; m_bank = 0; m_cent = 0; m_dalm = 0; m_ctla = 0; m_ctlb = 0;
    m_wcnt = 0; m_lo = 0; m_hi = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R2 reset", {7'd0, rd_valid}, 8'd0);

    // R1: upper half goes to user RAM with page bit 0
    wr_at(8'h45, 8'h11);
    wr_at(8'h12, 8'h5C);
    wr_at(8'h0A, 8'h10);            // page bit set
    rd_at(8'h45, "R7 serial byte");
    do_wr(8'h99);                   // R7 discarded
    do_rd("R7 read-only");
    rd_at(8'h40, "R7 model");
    rd_at(8'h47, "R7 crc");
    wr_at(8'h4C, 8'hEE);
    do_rd("R7 reserved");
    rd_at(8'h12, "R1 low half in page 1");
    wr_at(8'h0A, 8'h00);
    rd_at(8'h45, "R1 user RAM kept");

    // R8, R10
    wr_at(8'h0A, 8'h10);
    wr_at(8'h4A, 8'h00);
    do_rd("R8 aux bit");
    wr_at(8'h48, 8'h20); do_rd("R10 century");
    wr_at(8'h4B, 8'h3C); do_rd("R10 ctl b");

    // R3/R4: burst across low-byte wrap
    wr_at(8'h51, 8'h09);
    wr_at(8'h50, 8'hFE);
    wr_at(8'h4A, 8'h20);
    do_ale(8'h53);
    do_wr(8'hA1); do_wr(8'hA2); do_wr(8'hA3);
    rd_at(8'h50, "R4 low after burst");
    rd_at(8'h51, "R4 carry into high");
    chk("R5 small high ignored", small_last, 8'h00);
    wr_at(8'h4A, 8'h00);
    wr_at(8'h51, 8'h09);
    wr_at(8'h50, 8'hFE);
    rd_at(8'h53, "R3 modulo window");
    do_rd("R4 no burst");
    rd_at(8'h50, "R4 pointer held");
    wr_at(8'h50, 8'hFF);
    rd_at(8'h53, "R3 window");

    // R4/R5 on the 128-byte build: no carry into high
    wr_at(8'h4A, 8'h20);
    do_ale(8'h53); do_rd("R4 burst read");
    rd_at(8'h51, "R4 carry");
    chk("R4 small no carry", small_last, 8'h00);
    rd_at(8'h50, "R4 low wrapped");
    chk("R4 small low wrapped", small_last, 8'h00);
    rd_at(8'h40, "R7 model");
    chk("R7 small model", small_last, 8'h71);

    // R6: write counter
    rd_at(8'h5E, "R6 counter");
    do_wr(8'h00);
    do_rd("R6 counter after write");

    // R9: address history
    do_ale(8'h11); do_ale(8'h22);
    rd_at(8'h4E, "R9 entry 2");
    rd_at(8'h4F, "R9 entry 3");

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      int op;
      op = $urandom_range(0, 99);
      if (op < 30) begin
        if ($urandom_range(0, 1) == 0) do_ale(8'($urandom_range(0, 127)));
        else do_ale(8'($urandom_range(8'h40, 8'h5F)));
      end else if (op < 60) begin
        logic [7:0] d;
        d = 8'($urandom);
        if (m_idx == 7'h51) d = d & 8'h07;
        do_wr(d);
      end else begin
        do_rd(req_of());
      end
      if (n % 500 == 0) wr_at(8'h0A, 8'h10);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial void'($urandom(32'd12345));
endmodule